// File: doc/BRIEF.md
# Configuration Window Translator

This block sits on a processor I/O port bus and turns accesses to a pair of port windows into configuration read and write requests. Software first writes a 32-bit selector into the address port. That selector holds an enable flag and names a bus, a device, a function and a doubleword register. Software then reads or writes the data port, and the block forwards the access as a configuration cycle to the selected doubleword. I/O accesses that do not belong to the window are flagged back to the bus as ordinary I/O.

Requests to bus 0 go out as Type 0 cycles, and requests to any other bus go out as Type 1. Device 0 on bus 0 is the block's own hardwired bridge function, so those requests go to a separate internal strobe and are always claimed. All other requests wait for a claim from the target. If no claim arrives within a fixed window, the access is master-aborted: write data is dropped and read data is returned as all ones.

Top module: `cfg_window_xlat`

## Requirements
- R1: A write with all four byte enables (io_be = 4'b1111) to port 16'h0CF8 loads the selector. Bits 1:0 are stored as zero and bits 31:2 as written. A read of 16'h0CF8 with all enables returns the stored selector. Both complete with io_ack one cycle after io_req.
- R2: An access to 16'h0CF8..16'h0CFB without all four byte enables completes with io_pass one cycle after io_req and leaves the selector unchanged.
- R3: When selector bit 31 is 0, an access to the data port 16'h0CFC..16'h0CFF completes with io_pass, and neither cfg_req nor int_req is raised.
- R4: When bit 31 is 1 and the bus field (bits 23:16) is non-zero, a data-port access raises cfg_req with cfg_type1 = 1. It presents cfg_bus = bits 23:16, cfg_dev = bits 15:11, cfg_fn = bits 10:8 and cfg_dw = bits 7:2.
- R5: When bit 31 is 1, the bus is 0 and the device is non-zero, the request is raised on cfg_req with cfg_type1 = 0.
- R6: When bit 31 is 1 and both bus and device are 0, int_req pulses for one cycle and cfg_req stays low. The access completes with io_ack in the next cycle, returning int_rdata on a read.
- R7: On a forwarded access, cfg_be equals the I/O byte enables, cfg_wdata equals the I/O write data and cfg_wr equals io_wr. This lets byte and word accesses at 16'h0CFD..16'h0CFF select their lanes.
- R8: While cfg_req is high, a sampled cfg_claim drops cfg_req and raises io_ack in the next cycle. A read returns cfg_rdata, and a write returns zero on io_rdata.
- R9: If cfg_claim never arrives, cfg_req stays high for exactly TMO_CYC cycles. The access then completes with io_ack and a one-cycle cfg_abort, and a read returns 32'hFFFF_FFFF.
- R10: An access to any port outside 16'h0CF8..16'h0CFF completes with io_pass and starts no configuration cycle.
- R11: After reset the selector is zero and io_ack, io_pass, cfg_req, int_req and cfg_abort are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_req | input | 1 | One-cycle I/O access strobe, issued only while the block is idle |
| io_wr | input | 1 | 1 = I/O write, 0 = I/O read |
| io_addr | input | 16 | I/O port address |
| io_be | input | 4 | I/O byte enables, lane i covers bits 8i+7:8i |
| io_wdata | input | 32 | I/O write data |
| io_ack | output | 1 | Access completed by this block |
| io_pass | output | 1 | Access not handled here, to be routed as ordinary I/O |
| io_rdata | output | 32 | Read data, valid with io_ack |
| cfg_req | output | 1 | External configuration request, held until claim or timeout |
| int_req | output | 1 | One-cycle request to the internal bridge function |
| cfg_wr | output | 1 | Configuration write |
| cfg_type1 | output | 1 | 1 = Type 1 cycle, 0 = Type 0 cycle |
| cfg_bus | output | 8 | Target bus number |
| cfg_dev | output | 5 | Target device number |
| cfg_fn | output | 3 | Target function number |
| cfg_dw | output | 6 | Target doubleword register index |
| cfg_be | output | 4 | Configuration byte enables |
| cfg_wdata | output | 32 | Configuration write data |
| cfg_claim | input | 1 | Target claims and completes the pending cfg_req |
| cfg_rdata | input | 32 | Target read data, valid with cfg_claim |
| int_rdata | input | 32 | Internal bridge read data, sampled the cycle after int_req |
| cfg_abort | output | 1 | One-cycle master-abort indication |

## Verification
The embedded assertions check several rules on every cycle. A claim always ends a request one cycle later. A master abort on a read always carries all-ones data. The internal strobe always completes in the following cycle and never overlaps an external request. A disabled data-port access is always passed on. The selector's low two bits stay zero and the selector changes only on a full-width address write. The timeout counter never exceeds its limit.

Only the bench's scenarios can show the rest. These are the field extraction from a specific selector, the choice between Type 0 and Type 1 for particular bus values, and the pass-through of byte lanes and write data. They also include the exact request length on a timeout and the selector surviving a narrow address-port write.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

  localparam int IO_AW  = 16;
  localparam int DW     = 32;
  localparam int BEW    = DW / 8;
  localparam int BUS_W  = 8;
  localparam int DEV_W  = 5;
  localparam int FN_W   = 3;
  localparam int DWI_W  = 6;
  localparam int EN_BIT = 31;

  typedef enum logic [1:0] {
    PT_OTHER = 2'd0,
    PT_ADDR  = 2'd1,
    PT_DATA  = 2'd2
  } port_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EXT  = 2'd1,
    ST_INT  = 2'd2
  } st_e;

  typedef struct packed {
    logic [BUS_W-1:0] bus;
    logic [DEV_W-1:0] dev;
    logic [FN_W-1:0]  fn;
    logic [DWI_W-1:0] dwi;
  } tgt_t;

  // Classify a port address against the window base (base = selector port).
  function automatic port_e port_of(input logic [IO_AW-1:0] a,
                                    input logic [IO_AW-1:0] base);
    logic [IO_AW-1:0] data_base;
    data_base = base + IO_AW'(BEW);
    if (a[IO_AW-1:2] == base[IO_AW-1:2])           return PT_ADDR;
    else if (a[IO_AW-1:2] == data_base[IO_AW-1:2]) return PT_DATA;
    else                                           return PT_OTHER;
  endfunction

  // Value kept in the selector for a given write word.
  function automatic logic [DW-1:0] sel_store(input logic [DW-1:0] w);
    return {w[DW-1:2], 2'b00};
  endfunction

  // Split the selector into target fields.
  function automatic tgt_t tgt_of(input logic [DW-1:0] s);
    tgt_t t;
    t.bus = s[23:16];
    t.dev = s[15:11];
    t.fn  = s[10:8];
    t.dwi = s[7:2];
    return t;
  endfunction

  function automatic logic sel_enabled(input logic [DW-1:0] s);
    return s[EN_BIT];
  endfunction

  // Bus 0 device 0 is the hardwired internal bridge function.
  function automatic logic is_internal(input tgt_t t);
    return (t.bus == '0) && (t.dev == '0);
  endfunction

  function automatic logic is_type1(input tgt_t t);
    return t.bus != '0;
  endfunction

endpackage

// File: rtl/cfgx_port_dec.sv
module cfgx_port_dec
  import cfgx_pkg::*;
#(
  parameter logic [IO_AW-1:0] BASE = 16'h0CF8
) (
  input  logic             req,
  input  logic             wr,
  input  logic [IO_AW-1:0] addr,
  input  logic [BEW-1:0]   be,
  output logic             sel_load,
  output logic             sel_read,
  output logic             data_hit,
  output logic             other_hit
);

  port_e pt;
  logic  full;

  always_comb begin
    pt        = port_of(addr, BASE);
    full      = &be;
    sel_load  = req && (pt == PT_ADDR) && full && wr;
    sel_read  = req && (pt == PT_ADDR) && full && !wr;
    data_hit  = req && (pt == PT_DATA);
    other_hit = req && ((pt == PT_OTHER) || ((pt == PT_ADDR) && !full));
  end

  // the four decode outcomes never overlap
  always_comb begin
    decode_excl_chk: assert ($onehot0({sel_load, sel_read, data_hit, other_hit}));
  end

endmodule

// File: rtl/cfgx_sel_reg.sv
module cfgx_sel_reg
  import cfgx_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (ld) q <= sel_store(d);
  end

  // R1
  sel_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q[1:0] == 2'b00);

  // R2
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> $stable(q));

endmodule

// File: rtl/cfgx_tmo.sv
module cfgx_tmo #(
  parameter int TMO_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic claim,
  output logic expire
);

  localparam int CW = (TMO_CYC > 1) ? $clog2(TMO_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TMO_CYC - 1);

  logic [CW-1:0] cnt;

  assign expire = run && !claim && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !run || claim) cnt <= '0;
    else if (cnt != LAST)        cnt <= cnt + 1'b1;
  end

  // R9
  tmo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  // R9
  tmo_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt == '0);

endmodule

// File: rtl/cfg_window_xlat.sv
module cfg_window_xlat
  import cfgx_pkg::*;
#(
  parameter logic [15:0] BASE    = 16'h0CF8,
  parameter int          TMO_CYC = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        io_req,
  input  logic        io_wr,
  input  logic [15:0] io_addr,
  input  logic [3:0]  io_be,
  input  logic [31:0] io_wdata,
  output logic        io_ack,
  output logic        io_pass,
  output logic [31:0] io_rdata,
  output logic        cfg_req,
  output logic        int_req,
  output logic        cfg_wr,
  output logic        cfg_type1,
  output logic [7:0]  cfg_bus,
  output logic [4:0]  cfg_dev,
  output logic [2:0]  cfg_fn,
  output logic [5:0]  cfg_dw,
  output logic [3:0]  cfg_be,
  output logic [31:0] cfg_wdata,
  input  logic        cfg_claim,
  input  logic [31:0] cfg_rdata,
  input  logic [31:0] int_rdata,
  output logic        cfg_abort
);

  st_e           st;
  logic          idle;
  logic          sel_load, sel_read, data_hit, other_hit;
  logic [DW-1:0] sel_q;
  logic          sel_on;
  logic          tmo_expire;
  tgt_t          tgt_d, tgt_q;
  logic          start_int, start_ext, start_off;

  assign idle = (st == ST_IDLE);

  cfgx_port_dec #(.BASE(BASE)) u_dec (
    .req       (io_req && idle),
    .wr        (io_wr),
    .addr      (io_addr),
    .be        (io_be),
    .sel_load  (sel_load),
    .sel_read  (sel_read),
    .data_hit  (data_hit),
    .other_hit (other_hit)
  );

  cfgx_sel_reg u_sel (
    .clk   (clk),
    .rst_n (rst_n),
    .ld    (sel_load),
    .d     (io_wdata),
    .q     (sel_q)
  );

  cfgx_tmo #(.TMO_CYC(TMO_CYC)) u_tmo (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (st == ST_EXT),
    .claim  (cfg_claim),
    .expire (tmo_expire)
  );

  // named routing events
  always_comb begin
    tgt_d     = tgt_of(sel_q);
    sel_on    = sel_enabled(sel_q);
    start_off = data_hit && !sel_on;
    start_int = data_hit && sel_on && is_internal(tgt_d);
    start_ext = data_hit && sel_on && !is_internal(tgt_d);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      io_ack    <= 1'b0;
      io_pass   <= 1'b0;
      io_rdata  <= '0;
      cfg_req   <= 1'b0;
      int_req   <= 1'b0;
      cfg_abort <= 1'b0;
      cfg_wr    <= 1'b0;
      cfg_type1 <= 1'b0;
      tgt_q     <= '0;
      cfg_be    <= '0;
      cfg_wdata <= '0;
    end else begin
      io_ack    <= 1'b0;
      io_pass   <= 1'b0;
      int_req   <= 1'b0;
      cfg_abort <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (sel_load) begin
            io_ack   <= 1'b1;
            io_rdata <= '0;
          end else if (sel_read) begin
            io_ack   <= 1'b1;
            io_rdata <= sel_q;
          end else if (other_hit || start_off) begin
            io_pass  <= 1'b1;
            io_rdata <= '0;
          end else if (start_int || start_ext) begin
            tgt_q     <= tgt_d;
            cfg_type1 <= is_type1(tgt_d);
            cfg_wr    <= io_wr;
            cfg_be    <= io_be;
            cfg_wdata <= io_wdata;
            if (start_int) begin
              int_req <= 1'b1;
              st      <= ST_INT;
            end else begin
              cfg_req <= 1'b1;
              st      <= ST_EXT;
            end
          end
        end
        ST_EXT: begin
          if (cfg_claim) begin
            cfg_req  <= 1'b0;
            io_ack   <= 1'b1;
            io_rdata <= cfg_wr ? '0 : cfg_rdata;
            st       <= ST_IDLE;
          end else if (tmo_expire) begin
            cfg_req   <= 1'b0;
            io_ack    <= 1'b1;
            cfg_abort <= 1'b1;
            io_rdata  <= cfg_wr ? '0 : '1;
            st        <= ST_IDLE;
          end
        end
        ST_INT: begin
          io_ack   <= 1'b1;
          io_rdata <= cfg_wr ? '0 : int_rdata;
          st       <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign cfg_bus = tgt_q.bus;
  assign cfg_dev = tgt_q.dev;
  assign cfg_fn  = tgt_q.fn;
  assign cfg_dw  = tgt_q.dwi;

  // R8
  claim_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req && cfg_claim |=> io_ack && !cfg_req && !cfg_abort);

  // R9
  abort_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_abort && !cfg_wr |-> io_ack && (io_rdata == 32'hFFFF_FFFF));

  // R6
  int_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |=> io_ack && !cfg_req);

  // R6
  int_ext_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({int_req, cfg_req}));

  // R5
  ext_not_internal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> !((cfg_bus == 8'h00) && (cfg_dev == 5'h00)));

  // R3
  off_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_off |=> io_pass && !cfg_req && !int_req);

  // R10
  ack_pass_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({io_ack, io_pass}));

endmodule

// File: tb/cfg_window_xlat_bench.sv
module cfg_window_xlat_bench;

  localparam int TMO = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_req = 1'b0, io_wr = 1'b0;
  logic [15:0] io_addr = '0;
  logic [3:0]  io_be = '0;
  logic [31:0] io_wdata = '0;
  logic        io_ack, io_pass;
  logic [31:0] io_rdata;
  logic        cfg_req, int_req, cfg_wr, cfg_type1, cfg_abort;
  logic [7:0]  cfg_bus;
  logic [4:0]  cfg_dev;
  logic [2:0]  cfg_fn;
  logic [5:0]  cfg_dw;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic        cfg_claim = 1'b0;
  logic [31:0] cfg_rdata = '0, int_rdata = '0;

  always #10 clk = ~clk;

  cfg_window_xlat #(.TMO_CYC(TMO)) u_cfg_window_xlat (
    .clk(clk), .rst_n(rst_n), .io_req(io_req), .io_wr(io_wr), .io_addr(io_addr),
    .io_be(io_be), .io_wdata(io_wdata), .io_ack(io_ack), .io_pass(io_pass),
    .io_rdata(io_rdata), .cfg_req(cfg_req), .int_req(int_req), .cfg_wr(cfg_wr),
    .cfg_type1(cfg_type1), .cfg_bus(cfg_bus), .cfg_dev(cfg_dev), .cfg_fn(cfg_fn),
    .cfg_dw(cfg_dw), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_claim(cfg_claim),
    .cfg_rdata(cfg_rdata), .int_rdata(int_rdata), .cfg_abort(cfg_abort)
  );

  int n_chk = 0;
  int n_bad = 0;

  // observations from the last access
  logic        o_ack, o_pass, o_abort, o_type1, o_wr;
  logic [31:0] o_rd, o_wd;
  logic [7:0]  o_bus;
  logic [4:0]  o_dev;
  logic [2:0]  o_fn;
  logic [5:0]  o_dw;
  logic [3:0]  o_be;
  int          o_reqc, o_intc;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  localparam logic [7:0] NEVER = 8'hFF;

  // dly = claim in that request cycle (0 = first); NEVER = no claim
  task automatic run_io(input logic wr, input logic [15:0] a, input logic [3:0] be,
                        input logic [31:0] wd, input logic [7:0] dly, input logic [31:0] resp);
    @(negedge clk);
    io_req = 1'b1; io_wr = wr; io_addr = a; io_be = be; io_wdata = wd;
    cfg_rdata = resp; int_rdata = resp;
    o_ack = 0; o_pass = 0; o_abort = 0; o_rd = '0; o_reqc = 0; o_intc = 0;
    @(negedge clk);
    io_req = 1'b0;
    for (int i = 0; i < 64; i++) begin
      if (io_ack || io_pass) begin
        o_ack = io_ack; o_pass = io_pass; o_rd = io_rdata; o_abort = cfg_abort;
        break;
      end
      if (int_req) o_intc++;
      if (int_req || cfg_req) begin
        o_bus = cfg_bus; o_dev = cfg_dev; o_fn = cfg_fn; o_dw = cfg_dw;
        o_be = cfg_be; o_wd = cfg_wdata; o_wr = cfg_wr; o_type1 = cfg_type1;
      end
      if (cfg_req) begin
        o_reqc++;
        cfg_claim = (dly != NEVER) && (o_reqc == int'(dly) + 1);
      end else begin
        cfg_claim = 1'b0;
      end
      @(negedge clk);
    end
    cfg_claim = 1'b0;
  endtask

  typedef struct packed {
    logic        wr;
    logic [15:0] addr;
    logic [3:0]  be;
    logic [31:0] wd;
    logic [7:0]  dly;
    logic [31:0] resp;
    logic        pass;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 16'h0CF8, 4'hF, 32'h8012_3A4F, NEVER, 32'h0, 1'b0, 32'h0},            // R1 load
    '{1'b0, 16'h0CF8, 4'hF, 32'h0, NEVER, 32'h0, 1'b0, 32'h8012_3A4C},            // R1 readback
    '{1'b0, 16'h0CFC, 4'hF, 32'h0, 8'd2, 32'hDEAD_BEEF, 1'b0, 32'hDEAD_BEEF},     // R8 read
    '{1'b1, 16'h0CFC, 4'hF, 32'h1234_5678, NEVER, 32'h0, 1'b0, 32'h0},            // R9 write abort
    '{1'b0, 16'h0CFC, 4'hF, 32'h0, NEVER, 32'h5555_5555, 1'b0, 32'hFFFF_FFFF},    // R9 read abort
    '{1'b1, 16'h0CF8, 4'h3, 32'h0000_0000, NEVER, 32'h0, 1'b1, 32'h0},            // R2 narrow
    '{1'b0, 16'h0CF8, 4'hF, 32'h0, NEVER, 32'h0, 1'b0, 32'h8012_3A4C},            // R2 kept
    '{1'b1, 16'h0CF8, 4'hF, 32'h0000_0800, NEVER, 32'h0, 1'b0, 32'h0},            // R3 disable
    '{1'b0, 16'h0CFC, 4'hF, 32'h0, 8'd0, 32'h0, 1'b1, 32'h0},                     // R3 pass
    '{1'b0, 16'h0080, 4'hF, 32'h0, 8'd0, 32'h0, 1'b1, 32'h0},                     // R10 other
    '{1'b1, 16'h0CF8, 4'hF, 32'h8000_0000, NEVER, 32'h0, 1'b0, 32'h0},            // R6 select dev0
    '{1'b0, 16'h0CFE, 4'h4, 32'h0, NEVER, 32'h1122_3344, 1'b0, 32'h1122_3344},    // R6 internal read
    '{1'b1, 16'h0CF8, 4'hF, 32'h8000_5904, NEVER, 32'h0, 1'b0, 32'h0},            // R5 select
    '{1'b0, 16'h0CFC, 4'hF, 32'h0, 8'd0, 32'hCAFE_0001, 1'b0, 32'hCAFE_0001}      // R5 read
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 ack", {31'd0, io_ack}, 32'd0);
    chk("R11 req", {30'd0, cfg_req, int_req}, 32'd0);
    chk("R11 abort", {30'd0, cfg_abort, io_pass}, 32'd0);
    rst_n = 1'b1;
    run_io(1'b0, 16'h0CF8, 4'hF, 32'h0, NEVER, 32'h0);
    chk("R11 selector", o_rd, 32'h0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      run_io(VECS[v].wr, VECS[v].addr, VECS[v].be, VECS[v].wd, VECS[v].dly, VECS[v].resp);
      chk($sformatf("vec%0d kind", v), {31'd0, o_pass}, {31'd0, VECS[v].pass});
      chk($sformatf("vec%0d done", v), {31'd0, o_ack | o_pass}, 32'd1);
      if (!VECS[v].pass) chk($sformatf("vec%0d rdata", v), o_rd, VECS[v].exp);
      if (v == 8 || v == 9) chk($sformatf("R3/R10 vec%0d no req", v), o_reqc + o_intc, 0);
      if (v == 11) begin
        chk("R6 int pulses", o_intc, 1);
        chk("R6 no cfg_req", o_reqc, 0);
      end
      if (v == 13) begin
        chk("R5 type0", {31'd0, o_type1}, 32'd0);
        chk("R5 dev", {27'd0, o_dev}, 32'd11);
        chk("R5 fn/dw", {21'd0, o_fn, o_dw}, {21'd0, 3'd1, 6'd1});
      end
    end

    // R4/R7: Type 1 fields and lane pass-through
    run_io(1'b1, 16'h0CF8, 4'hF, 32'h8012_3A4C, NEVER, 32'h0);
    run_io(1'b1, 16'h0CFD, 4'b0010, 32'h0000_AB00, 8'd1, 32'h0);
    chk("R4 type1", {31'd0, o_type1}, 32'd1);
    chk("R4 bus", {24'd0, o_bus}, 32'h12);
    chk("R4 dev", {27'd0, o_dev}, 32'd7);
    chk("R4 fn", {29'd0, o_fn}, 32'd2);
    chk("R4 dw", {26'd0, o_dw}, 32'h13);
    chk("R7 be", {28'd0, o_be}, 32'h2);
    chk("R7 wdata", o_wd, 32'h0000_AB00);
    chk("R7 wr", {31'd0, o_wr}, 32'd1);
    chk("R8 claim after 2 cycles", o_reqc, 2);
    chk("R8 write rdata", o_rd, 32'h0);

    // R9 timeout length
    run_io(1'b0, 16'h0CFF, 4'b1000, 32'h0, NEVER, 32'h0);
    chk("R9 req cycles", o_reqc, TMO);
    chk("R9 abort flag", {31'd0, o_abort}, 32'd1);
    chk("R9 ones", o_rd, 32'hFFFF_FFFF);
    chk("R7 be byte3", {28'd0, o_be}, 32'h8);

    // R2 narrow read of selector port passes, selector kept
    run_io(1'b0, 16'h0CFA, 4'b1100, 32'h0, NEVER, 32'h0);
    chk("R2 narrow read pass", {31'd0, o_pass}, 32'd1);
    run_io(1'b0, 16'h0CF8, 4'hF, 32'h0, NEVER, 32'h0);
    chk("R2 selector kept", o_rd, 32'h8012_3A4C);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule